// File: doc/BRIEF.md
# Calendar Clock Timer with Alarm

This block keeps wall-clock time for a chip from a 256 Hz tick enable, which is derived outside the block from a 32.768 kHz oscillator. An 8-bit binary prescaler counts the ticks. Each of its bits is a square wave, from 128 Hz at bit 0 down to 1 Hz at bit 7. Each wrap of the prescaler advances a chain of counters for seconds, minutes and hours. A 16-bit day counter follows the hours. Software reads every counter over a simple synchronous register bus. The bus can also start and stop counting and clear the time.

Software can enable eight interrupt sources. Four are fixed prescaler taps, at 32, 8, 2 and 1 Hz. Three are the completion of a minute, an hour and a day. The last is an alarm. The alarm compares any chosen subset of minute, hour and the low five bits of the day against programmed values. It fires a single-cycle pulse on the cycle the chosen fields first become equal. Every source has a sticky flag that is cleared by writing 1, and the interrupt request is the OR of the enabled flags.

Register addresses on `bus_addr`: 0 control (bit 0 run, bit 1 clear when written as 1, which reads back as 0), 1 prescaler, 2 seconds, 3 minutes, 4 hours, 5 day, 6 minute compare, 7 hour compare, 8 day compare, 9 alarm field select, 10 interrupt enable, 11 interrupt flags. Reads are combinational from `bus_addr`. Writes take effect at the clock edge where `bus_we` is high. Any other address reads as zero.

Top module: `calclk_top`

## Requirements
- R1: The synchronous reset `rst` clears the prescaler, all time counters, the run bit, the compare registers, the alarm select, the interrupt enables and the flags. After reset, every register reads 0 and `irq` and `alarm` are low.
- R2: While running, each clock edge with `tick_256` high advances the 8-bit prescaler (address 1) by one, and it wraps from 255 to 0.
- R3: Seconds advance when the prescaler wraps from 255 to 0. Minutes advance when seconds wrap. Hours advance when minutes wrap. The day counter advances when hours wrap. Seconds, minutes and hours wrap to 0 after the values SEC_LAST, MIN_LAST and HOUR_LAST (defaults 59, 59 and 23). The day counter wraps from 65535 to 0.
- R4: With control bit 0 (run) at 0, `tick_256` is ignored. All counters keep their values and stay readable.
- R5: Writing control with bit 1 set zeroes the prescaler and all time counters at that edge, even if `tick_256` is high in the same cycle. The compare registers keep their values.
- R6: Flag bits 0, 1, 2 and 3 (32, 8, 2 and 1 Hz) are set on the tick where prescaler bit 2, 4, 6 or 7 goes from 0 to 1.
- R7: Flag bit 4 is set when seconds wrap (a minute completes). Flag bit 5 is set when minutes wrap (an hour completes). Flag bit 6 is set when hours wrap (a day completes).
- R8: Flags (address 11) are sticky. Writing 1 to a bit clears that bit. If a new event for a bit arrives in the same cycle as a clear, the bit ends up set.
- R9: `irq` is high exactly when some flag bit is set and the same bit of the enable register (address 10) is set.
- R10: Alarm select bit 0 chooses minutes, bit 1 chooses hours and bit 2 chooses the low 5 bits of the day. A match needs at least one field chosen and every chosen field equal to its compare register. `alarm` pulses for one cycle when a match begins, stays low while the match lasts, and sets flag bit 7.
- R11: The compare registers (addresses 6, 7 and 8, widths 6, 5 and 5 bits) and the select register read back the values written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_256 | input | 1 | One-cycle 256 Hz count enable |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| irq | output | 1 | Interrupt request, OR of enabled flags |
| alarm | output | 1 | One-cycle alarm pulse on match entry |

## Verification
The bound checker looks at every cycle for several things. It checks that the prescaler steps by exactly one on each accepted tick and stays still, along with the time, while stopped. It checks that a clear leaves every counter at zero. It checks that seconds never exceed their last value, that flags never drop without a write-one-to-clear, that `irq` never rises with no flag set, and that the alarm never lasts two cycles. Only the bench's scenarios can show the rest. They show the cascade values at chosen tick counts, that each tap flag sets on the exact tick, and the unit-rollover flags. They also show that an event wins over a same-cycle clear and that the alarm fires for each field selection.

// File: rtl/calclk_pkg.sv
package calclk_pkg;

    localparam int PRE_W    = 8;
    localparam int SEC_W    = 6;
    localparam int MIN_W    = 6;
    localparam int HR_W     = 5;
    localparam int DAY_W    = 16;
    localparam int DCMP_W   = 5;
    localparam int ADDR_W   = 4;
    localparam int DATA_W   = 16;
    localparam int NUM_TAPS = 4;
    localparam int NUM_SRC  = 8;

    localparam int SRC_MIN  = 4;
    localparam int SRC_HR   = 5;
    localparam int SRC_DAY  = 6;
    localparam int SRC_ALM  = 7;

    localparam int CTRL_RUN = 0;
    localparam int CTRL_CLR = 1;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL      = 4'd0,
        REG_PRESC     = 4'd1,
        REG_SEC       = 4'd2,
        REG_MIN       = 4'd3,
        REG_HOUR      = 4'd4,
        REG_DAY       = 4'd5,
        REG_CMP_MIN   = 4'd6,
        REG_CMP_HOUR  = 4'd7,
        REG_CMP_DAY   = 4'd8,
        REG_ALM_SEL   = 4'd9,
        REG_IRQ_EN    = 4'd10,
        REG_IRQ_FLAG  = 4'd11
    } reg_addr_e;

    typedef struct packed {
        logic [DAY_W-1:0] day;
        logic [HR_W-1:0]  hour;
        logic [MIN_W-1:0] min;
        logic [SEC_W-1:0] sec;
    } time_t;

    typedef struct packed {
        logic [DCMP_W-1:0] day;
        logic [HR_W-1:0]   hour;
        logic [MIN_W-1:0]  min;
    } alarm_cmp_t;

    typedef struct packed {
        logic day;
        logic hour;
        logic min;
    } alarm_sel_t;

    typedef struct packed {
        logic hour_wrap;
        logic min_wrap;
        logic sec_wrap;
    } roll_t;

    // Prescaler bit watched by tap source g (32, 8, 2, 1 Hz).
    function automatic int tap_bit(input int g);
        case (g)
            0:       return 2;
            1:       return 4;
            2:       return 6;
            default: return 7;
        endcase
    endfunction

    // True when incrementing cur turns bit idx from 0 to 1.
    function automatic logic bit_rises(input logic [PRE_W-1:0] cur, input int idx);
        logic [PRE_W-1:0] nxt;
        nxt = cur + 1'b1;
        return !cur[idx] && nxt[idx];
    endfunction

endpackage

// File: rtl/calclk_modcnt.sv
module calclk_modcnt #(
    parameter int          W    = 6,
    parameter int unsigned LAST = 59
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] val,
    output logic         wrap
);
    localparam logic [W-1:0] LAST_V = W'(LAST);

    assign wrap = inc && (val == LAST_V);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            val <= '0;
        end else if (inc) begin
            val <= wrap ? '0 : val + 1'b1;
        end
    end
endmodule

// File: rtl/calclk_prescaler.sv
module calclk_prescaler
    import calclk_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic                 adv,
    output logic [PRE_W-1:0]     cnt,
    output logic [NUM_TAPS-1:0]  tap_rise,
    output logic                 sec_tick
);
    assign sec_tick = adv && (cnt == {PRE_W{1'b1}});

    for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
        assign tap_rise[g] = adv && bit_rises(cnt, tap_bit(g));
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (adv) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/calclk_timecnt.sv
module calclk_timecnt
    import calclk_pkg::*;
#(
    parameter int unsigned SEC_LAST  = 59,
    parameter int unsigned MIN_LAST  = 59,
    parameter int unsigned HOUR_LAST = 23
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  logic  sec_tick,
    output time_t now,
    output roll_t roll
);
    localparam int unsigned DAY_LAST = (1 << DAY_W) - 1;

    logic day_wrap;

    calclk_modcnt #(.W(SEC_W), .LAST(SEC_LAST)) u_sec (
        .clk(clk), .rst(rst), .clr(clr), .inc(sec_tick),
        .val(now.sec), .wrap(roll.sec_wrap)
    );

    calclk_modcnt #(.W(MIN_W), .LAST(MIN_LAST)) u_min (
        .clk(clk), .rst(rst), .clr(clr), .inc(roll.sec_wrap),
        .val(now.min), .wrap(roll.min_wrap)
    );

    calclk_modcnt #(.W(HR_W), .LAST(HOUR_LAST)) u_hour (
        .clk(clk), .rst(rst), .clr(clr), .inc(roll.min_wrap),
        .val(now.hour), .wrap(roll.hour_wrap)
    );

    calclk_modcnt #(.W(DAY_W), .LAST(DAY_LAST)) u_day (
        .clk(clk), .rst(rst), .clr(clr), .inc(roll.hour_wrap),
        .val(now.day), .wrap(day_wrap)
    );

    logic unused_day_wrap;
    assign unused_day_wrap = day_wrap;
endmodule

// File: rtl/calclk_alarm.sv
module calclk_alarm
    import calclk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  time_t      now,
    input  alarm_cmp_t cmp,
    input  alarm_sel_t sel,
    output logic       hit
);
    logic match_now;
    logic match_q;
    logic min_ok;
    logic hour_ok;
    logic day_ok;

    always_comb begin
        min_ok    = !sel.min  || (now.min  == cmp.min);
        hour_ok   = !sel.hour || (now.hour == cmp.hour);
        day_ok    = !sel.day  || (now.day[DCMP_W-1:0] == cmp.day);
        match_now = (sel != '0) && min_ok && hour_ok && day_ok;
    end

    always_ff @(posedge clk) begin
        if (rst) match_q <= 1'b0;
        else     match_q <= match_now;
    end

    assign hit = match_now && !match_q;
endmodule

// File: rtl/calclk_irq.sv
module calclk_irq
    import calclk_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] set_ev,
    input  logic [NUM_SRC-1:0] clr_mask,
    input  logic [NUM_SRC-1:0] en,
    output logic [NUM_SRC-1:0] flags,
    output logic               irq
);
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst)            flags[s] <= 1'b0;
            else if (set_ev[s]) flags[s] <= 1'b1;
            else if (clr_mask[s]) flags[s] <= 1'b0;
        end
    end

    assign irq = |(flags & en);
endmodule

// File: rtl/calclk_top.sv
module calclk_top
    import calclk_pkg::*;
#(
    parameter int unsigned SEC_LAST  = 59,
    parameter int unsigned MIN_LAST  = 59,
    parameter int unsigned HOUR_LAST = 23
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_256,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              alarm
);
    logic               run_q;
    alarm_cmp_t         cmp_q;
    alarm_sel_t         sel_q;
    logic [NUM_SRC-1:0] irq_en_q;

    logic               wr_ctrl;
    logic               clr_pulse;
    logic               adv;
    logic [PRE_W-1:0]   presc_cnt;
    logic [NUM_TAPS-1:0] tap_rise;
    logic               sec_tick;
    time_t              now;
    roll_t              roll;
    logic               alarm_hit;
    logic [NUM_SRC-1:0] set_ev;
    logic [NUM_SRC-1:0] w1c_mask;
    logic [NUM_SRC-1:0] irq_flags;
    reg_addr_e          addr_e;

    assign addr_e    = reg_addr_e'(bus_addr);
    assign wr_ctrl   = bus_we && (addr_e == REG_CTRL);
    assign clr_pulse = wr_ctrl && bus_wdata[CTRL_CLR];
    assign adv       = run_q && tick_256 && !clr_pulse;
    assign w1c_mask  = (bus_we && addr_e == REG_IRQ_FLAG) ? bus_wdata[NUM_SRC-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q    <= 1'b0;
            cmp_q    <= '0;
            sel_q    <= '0;
            irq_en_q <= '0;
        end else if (bus_we) begin
            case (addr_e)
                REG_CTRL:     run_q    <= bus_wdata[CTRL_RUN];
                REG_CMP_MIN:  cmp_q.min  <= bus_wdata[MIN_W-1:0];
                REG_CMP_HOUR: cmp_q.hour <= bus_wdata[HR_W-1:0];
                REG_CMP_DAY:  cmp_q.day  <= bus_wdata[DCMP_W-1:0];
                REG_ALM_SEL:  sel_q    <= bus_wdata[2:0];
                REG_IRQ_EN:   irq_en_q <= bus_wdata[NUM_SRC-1:0];
                default:      ;
            endcase
        end
    end

    calclk_prescaler u_pre (
        .clk(clk), .rst(rst), .clr(clr_pulse), .adv(adv),
        .cnt(presc_cnt), .tap_rise(tap_rise), .sec_tick(sec_tick)
    );

    calclk_timecnt #(
        .SEC_LAST(SEC_LAST), .MIN_LAST(MIN_LAST), .HOUR_LAST(HOUR_LAST)
    ) u_time (
        .clk(clk), .rst(rst), .clr(clr_pulse), .sec_tick(sec_tick),
        .now(now), .roll(roll)
    );

    calclk_alarm u_alm (
        .clk(clk), .rst(rst), .now(now), .cmp(cmp_q), .sel(sel_q), .hit(alarm_hit)
    );

    always_comb begin
        set_ev                     = '0;
        set_ev[NUM_TAPS-1:0]       = tap_rise;
        set_ev[SRC_MIN]            = roll.sec_wrap;
        set_ev[SRC_HR]             = roll.min_wrap;
        set_ev[SRC_DAY]            = roll.hour_wrap;
        set_ev[SRC_ALM]            = alarm_hit;
    end

    calclk_irq u_irq (
        .clk(clk), .rst(rst), .set_ev(set_ev), .clr_mask(w1c_mask),
        .en(irq_en_q), .flags(irq_flags), .irq(irq)
    );

    assign alarm = alarm_hit;

    always_comb begin
        bus_rdata = '0;
        case (addr_e)
            REG_CTRL:     bus_rdata = DATA_W'(run_q);
            REG_PRESC:    bus_rdata = DATA_W'(presc_cnt);
            REG_SEC:      bus_rdata = DATA_W'(now.sec);
            REG_MIN:      bus_rdata = DATA_W'(now.min);
            REG_HOUR:     bus_rdata = DATA_W'(now.hour);
            REG_DAY:      bus_rdata = DATA_W'(now.day);
            REG_CMP_MIN:  bus_rdata = DATA_W'(cmp_q.min);
            REG_CMP_HOUR: bus_rdata = DATA_W'(cmp_q.hour);
            REG_CMP_DAY:  bus_rdata = DATA_W'(cmp_q.day);
            REG_ALM_SEL:  bus_rdata = DATA_W'(sel_q);
            REG_IRQ_EN:   bus_rdata = DATA_W'(irq_en_q);
            REG_IRQ_FLAG: bus_rdata = DATA_W'(irq_flags);
            default:      bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/calclk_checker.sv
module calclk_checker
    import calclk_pkg::*;
#(
    parameter int unsigned SEC_LAST = 59
) (
    input logic               clk,
    input logic               rst,
    input logic               tick,
    input logic               run,
    input logic               clr,
    input logic [PRE_W-1:0]   presc,
    input time_t              now,
    input logic [NUM_SRC-1:0] flags,
    input logic [NUM_SRC-1:0] w1c,
    input logic               irq,
    input logic               alarm
);
    assert_presc_step_R2: assert property (@(posedge clk) disable iff (rst)
        (run && tick && !clr) |=> (presc == $past(presc) + 1'b1));

    assert_sec_range_R3: assert property (@(posedge clk) disable iff (rst)
        32'(now.sec) <= SEC_LAST);

    assert_hold_stopped_R4: assert property (@(posedge clk) disable iff (rst)
        (!run && !clr) |=> ($stable(presc) && $stable(now)));

    assert_clear_zero_R5: assert property (@(posedge clk) disable iff (rst)
        clr |=> (presc == '0 && now == '0));

    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (w1c == '0) |=> ((flags & $past(flags)) == $past(flags)));

    assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (rst)
        irq |-> (flags != '0));

    assert_alarm_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        alarm |=> !alarm);
endmodule

bind calclk_top calclk_checker #(.SEC_LAST(SEC_LAST)) u_chk (
    .clk(clk), .rst(rst), .tick(tick_256), .run(run_q), .clr(clr_pulse),
    .presc(presc_cnt), .now(now), .flags(irq_flags), .w1c(w1c_mask),
    .irq(irq), .alarm(alarm)
);

// File: tb/calclk_top_tb.sv
module calclk_top_tb;
    import calclk_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              tick_256 = 1'b0;
    logic              bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              irq;
    logic              alarm;

    int checks = 0;
    int failures = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    // Short units so that every rollover fits in the run:
    // 4 seconds per minute, 3 minutes per hour, 3 hours per day.
    calclk_top #(.SEC_LAST(3), .MIN_LAST(2), .HOUR_LAST(2)) u_dut (
        .clk(clk), .rst(rst), .tick_256(tick_256), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .alarm(alarm)
    );

    typedef struct packed {
        logic [31:0] step;
        logic [7:0]  p;
        logic [5:0]  s;
        logic [5:0]  m;
        logic [4:0]  h;
        logic [15:0] d;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{32'd1,    8'd1,   6'd0, 6'd0, 5'd0, 16'd0},
        '{32'd254,  8'd255, 6'd0, 6'd0, 5'd0, 16'd0},
        '{32'd1,    8'd0,   6'd1, 6'd0, 5'd0, 16'd0},
        '{32'd768,  8'd0,   6'd0, 6'd1, 5'd0, 16'd0},
        '{32'd2047, 8'd255, 6'd3, 6'd2, 5'd0, 16'd0},
        '{32'd1,    8'd0,   6'd0, 6'd0, 5'd1, 16'd0},
        '{32'd6144, 8'd0,   6'd0, 6'd0, 5'd0, 16'd1},
        '{32'd5000, 8'd136, 6'd3, 6'd1, 5'd1, 16'd1}
    };

    task automatic check(input string req, input logic [DATA_W-1:0] act,
                         input logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input reg_addr_e a, input logic [DATA_W-1:0] d);
        bus_we = 1'b1;
        bus_addr = a;
        bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input reg_addr_e a, output logic [DATA_W-1:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_256 = 1'b1;
            @(negedge clk);
        end
        tick_256 = 1'b0;
    endtask

    initial begin
        logic [DATA_W-1:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int a = 0; a <= 11; a++) begin
            rd(reg_addr_e'(a), v);
            check("R1 reg after reset", v, '0);
        end
        check("R1 irq after reset", {15'd0, irq}, 16'd0);
        check("R1 alarm after reset", {15'd0, alarm}, 16'd0);

        // R2 R3 table walk
        wr(REG_CTRL, 16'h0001);
        for (int i = 0; i < NV; i++) begin
            ticks(int'(VECS[i].step));
            rd(REG_PRESC, v); check("R2 prescaler", v, 16'(VECS[i].p));
            rd(REG_SEC, v);   check("R3 seconds", v, 16'(VECS[i].s));
            rd(REG_MIN, v);   check("R3 minutes", v, 16'(VECS[i].m));
            rd(REG_HOUR, v);  check("R3 hours", v, 16'(VECS[i].h));
            rd(REG_DAY, v);   check("R3 day", v, VECS[i].d);
        end

        // R4 stop holds counters
        wr(REG_CTRL, 16'h0000);
        ticks(50);
        rd(REG_PRESC, v); check("R4 prescaler held", v, 16'd136);
        rd(REG_SEC, v);   check("R4 seconds held", v, 16'd3);
        rd(REG_DAY, v);   check("R4 day held", v, 16'd1);

        // R11 compare registers, R5 clear keeps them
        wr(REG_CMP_MIN, 16'd2);
        wr(REG_CMP_HOUR, 16'd1);
        wr(REG_CMP_DAY, 16'd5);
        wr(REG_CTRL, 16'h0002);
        rd(REG_PRESC, v); check("R5 prescaler cleared", v, 16'd0);
        rd(REG_MIN, v);   check("R5 minutes cleared", v, 16'd0);
        rd(REG_HOUR, v);  check("R5 hours cleared", v, 16'd0);
        rd(REG_DAY, v);   check("R5 day cleared", v, 16'd0);
        rd(REG_CMP_MIN, v);  check("R11 minute compare kept", v, 16'd2);
        rd(REG_CMP_HOUR, v); check("R11 hour compare kept", v, 16'd1);
        rd(REG_CMP_DAY, v);  check("R11 day compare kept", v, 16'd5);
        ticks(3);
        wr(REG_CTRL, 16'h0000);
        tick_256 = 1'b1;
        wr(REG_CTRL, 16'h0003);
        tick_256 = 1'b0;
        rd(REG_PRESC, v); check("R5 clear wins over tick", v, 16'd0);
        rd(REG_CTRL, v);  check("R5 control reads run only", v, 16'd1);

        // R6 32 Hz tap, R9 irq
        wr(REG_IRQ_FLAG, 16'h00FF);
        wr(REG_IRQ_EN, 16'h0001);
        ticks(3);
        rd(REG_IRQ_FLAG, v); check("R6 32Hz not yet", v, 16'h0000);
        check("R9 irq low without flag", {15'd0, irq}, 16'd0);
        ticks(1);
        rd(REG_IRQ_FLAG, v); check("R6 32Hz on bit2 rise", v, 16'h0001);
        check("R9 irq high with enabled flag", {15'd0, irq}, 16'd1);

        // R8 write-one-to-clear
        wr(REG_IRQ_FLAG, 16'h0001);
        rd(REG_IRQ_FLAG, v); check("R8 flag cleared", v, 16'h0000);
        check("R9 irq drops", {15'd0, irq}, 16'd0);

        // R6 remaining taps up to the 1 Hz edge
        ticks(123);
        rd(REG_IRQ_FLAG, v); check("R6 taps before 1Hz", v, 16'h0007);
        ticks(1);
        rd(REG_IRQ_FLAG, v); check("R6 1Hz on bit7 rise", v, 16'h000F);
        wr(REG_IRQ_EN, 16'h0002);
        check("R9 irq from 8Hz enable", {15'd0, irq}, 16'd1);
        wr(REG_IRQ_EN, 16'h0000);
        check("R9 irq masked", {15'd0, irq}, 16'd0);

        // R8 event wins over same-cycle clear
        wr(REG_IRQ_FLAG, 16'h00FF);
        ticks(3);
        rd(REG_IRQ_FLAG, v); check("R8 no event yet", v, 16'h0000);
        tick_256 = 1'b1;
        wr(REG_IRQ_FLAG, 16'h0001);
        tick_256 = 1'b0;
        rd(REG_IRQ_FLAG, v); check("R8 set beats clear", v & 16'h0001, 16'h0001);

        // R7 unit rollover flags (time since clear is now 132 ticks)
        wr(REG_IRQ_FLAG, 16'h00FF);
        ticks(891);
        rd(REG_IRQ_FLAG, v); check("R7 minute flag before wrap", v & 16'h0010, 16'h0000);
        ticks(1);
        rd(REG_IRQ_FLAG, v); check("R7 minute flag", v & 16'h0070, 16'h0010);
        ticks(2047);
        rd(REG_IRQ_FLAG, v); check("R7 hour flag before wrap", v & 16'h0020, 16'h0000);
        ticks(1);
        rd(REG_IRQ_FLAG, v); check("R7 hour flag", v & 16'h0060, 16'h0020);
        ticks(6144);
        rd(REG_IRQ_FLAG, v); check("R7 day flag", v & 16'h0040, 16'h0040);

        // R10 alarm on minutes only
        wr(REG_CTRL, 16'h0003);
        wr(REG_ALM_SEL, 16'h0001);
        rd(REG_ALM_SEL, v); check("R11 select readback", v, 16'h0001);
        wr(REG_IRQ_FLAG, 16'h00FF);
        ticks(2047);
        check("R10 no alarm before match", {15'd0, alarm}, 16'd0);
        ticks(1);
        check("R10 alarm on minute match", {15'd0, alarm}, 16'd1);
        @(negedge clk);
        check("R10 alarm one cycle", {15'd0, alarm}, 16'd0);
        rd(REG_IRQ_FLAG, v); check("R10 alarm flag", v & 16'h0080, 16'h0080);
        ticks(1);
        check("R10 no repeat while equal", {15'd0, alarm}, 16'd0);

        // R10 minutes and hours together (time now 2049)
        wr(REG_ALM_SEL, 16'h0003);
        ticks(3070);
        check("R10 no alarm before min+hour", {15'd0, alarm}, 16'd0);
        ticks(1);
        check("R10 alarm on min+hour", {15'd0, alarm}, 16'd1);

        // R10 day low bits (time now 5120, day 5 at 46080)
        wr(REG_ALM_SEL, 16'h0004);
        ticks(40959);
        check("R10 no alarm before day", {15'd0, alarm}, 16'd0);
        ticks(1);
        check("R10 alarm on day match", {15'd0, alarm}, 16'd1);
        rd(REG_DAY, v); check("R3 day count at alarm", v, 16'd5);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule